// File: doc/BRIEF.md
# Flash Page Program Buffer

This block stages one full page of data for a serial NOR flash so that software can program the page with a single command. A mode bit turns the shared buffer from its read-prefetch role into a write staging area; software confirms the switch by reading the bit back. It then packs the page into the buffer through a 32-bit data port, four bytes per write, and sets the target flash address through byte-wide address registers.

A program command then drives one uninterrupted serial burst with chip select held low throughout: the page-program opcode, the address (three or four bytes), then every byte of the buffer in fill order. The command bit stays set while the burst runs and drops by itself when chip select has been released. The fill pointer then returns to the first word, so the next page can be loaded at once.

Top module: `flash_page_buffer`

## Requirements
- R1: After reset every register reads as zero, chip select (active low) is high and the serial clock is low.
- R2: Bit 0 of the configuration register at offset 0x24 selects the buffer use (0 = read prefetch, 1 = page program). The bit reads back the mode in force. A change requested while a burst runs reads back as the old value until the burst ends, and the new value afterwards.
- R3: Writes to the data port at offset 0x28 are stored only in page-program mode. Bits 7:0 of each word are sent first, then bits 15:8, 23:16 and 31:24. In read-prefetch mode a data-port write stores nothing and does not advance the fill position.
- R4: The buffer accepts at most BUF_BYTES/4 words (32 by default) per page. Further data-port writes are ignored until the fill position is reset.
- R5: The address byte registers are at 0x10 (bits 7:0), 0x14 (bits 15:8), 0x18 (bits 23:16) and 0x2C (bits 31:24). Each reads back the byte that was written to it in bits 7:0.
- R6: Bit 4 of the mode register at offset 0x20 selects 4-byte addressing. With it clear, only address bits 23:0 are sent. The address bytes are sent most significant first.
- R7: Writing a value with bit 4 set to the command register at offset 0x00, in page-program mode, starts one burst. Chip select goes low, then opcode 0x02, the address and BUF_BYTES data bytes are sent, and then chip select goes high. Each byte is sent MSB first, and the data line is stable at each rising clock edge (SPI mode 0).
- R8: Bit 4 of the command register reads 1 from the cycle after the start command until the burst has ended, and reads 0 otherwise.
- R9: A start command issued in read-prefetch mode is ignored: chip select does not fall and the command bit stays 0.
- R10: Once a burst completes, the fill position returns to word 0, so the next page's first data-port write becomes the first data byte of the next burst.
- R11: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr, one cycle later |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The bench loads pages while the buffer is still in read-prefetch mode. A design that stored those writes would shift the page so that it no longer starts at the first byte loaded after the switch. It writes one word past the end of the page; a design without a bound would wrap and overwrite the first word, or the last word. It requests a mode change in the middle of a burst and expects the old mode to read back until chip select rises; a premature switch would show up in that readback. It checks the 3-byte and 4-byte address framings, where a byte-order error changes the address bytes and so moves every data byte in the stream. It also runs two bursts back to back, which exposes a fill position that is not reset after the first.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_AD0  = 8'h10;
  localparam logic [7:0] OFS_AD1  = 8'h14;
  localparam logic [7:0] OFS_AD2  = 8'h18;
  localparam logic [7:0] OFS_MODE = 8'h20;
  localparam logic [7:0] OFS_CFG  = 8'h24;
  localparam logic [7:0] OFS_DATA = 8'h28;
  localparam logic [7:0] OFS_AD3  = 8'h2C;

  localparam int CMD_PROG_BIT = 4;
  localparam int MODE_4B_BIT  = 4;
  localparam logic [7:0] PP_OPCODE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_FETCH, ST_SHIFT, ST_TAIL, ST_END
  } eng_state_t;
endpackage

// File: rtl/fpb_ram.sv
module fpb_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpb_regs.sv
module fpb_regs
  import fpb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    reg_addr,
  input  logic          reg_wen,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          eng_busy,
  input  logic          eng_done,
  output logic          start_o,
  output logic [31:0]   addr_o,
  output logic          four_b_o,
  output logic          ram_we,
  output logic [IW-1:0] ram_waddr,
  output logic [31:0]   ram_wdata
);
  logic          start_q;
  logic          cfg_req, cfg_eff;
  logic          four_b_q;
  logic [31:0]   addr_q;
  logic [PW-1:0] ptr;
  logic          busy_all;
  logic          accept;

  assign busy_all  = start_q | eng_busy;
  assign accept    = reg_wen && (reg_addr == OFS_DATA) && cfg_eff && !busy_all
                     && (ptr < PW'(DEPTH));
  assign ram_we    = accept;
  assign ram_waddr = ptr[IW-1:0];
  assign ram_wdata = reg_wdata;
  assign start_o   = start_q;
  assign addr_o    = addr_q;
  assign four_b_o  = four_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      cfg_req  <= 1'b0;
      cfg_eff  <= 1'b0;
      four_b_q <= 1'b0;
      addr_q   <= '0;
      ptr      <= '0;
    end else begin
      start_q <= reg_wen && (reg_addr == OFS_CMD) && reg_wdata[CMD_PROG_BIT]
                 && cfg_eff && !busy_all;
      if (reg_wen) begin
        unique case (reg_addr)
          OFS_AD0:  addr_q[7:0]   <= reg_wdata[7:0];
          OFS_AD1:  addr_q[15:8]  <= reg_wdata[7:0];
          OFS_AD2:  addr_q[23:16] <= reg_wdata[7:0];
          OFS_AD3:  addr_q[31:24] <= reg_wdata[7:0];
          OFS_MODE: four_b_q      <= reg_wdata[MODE_4B_BIT];
          OFS_CFG:  cfg_req       <= reg_wdata[0];
          default: ;
        endcase
      end
      if (!busy_all) cfg_eff <= cfg_req;
      if (eng_done || !cfg_eff) ptr <= '0;
      else if (accept) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        OFS_CMD:  reg_rdata <= 32'(busy_all) << CMD_PROG_BIT;
        OFS_AD0:  reg_rdata <= {24'h0, addr_q[7:0]};
        OFS_AD1:  reg_rdata <= {24'h0, addr_q[15:8]};
        OFS_AD2:  reg_rdata <= {24'h0, addr_q[23:16]};
        OFS_AD3:  reg_rdata <= {24'h0, addr_q[31:24]};
        OFS_MODE: reg_rdata <= 32'(four_b_q) << MODE_4B_BIT;
        OFS_CFG:  reg_rdata <= {31'h0, cfg_eff};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R4: the fill position never runs past the page
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(DEPTH));
  // R10: a finished burst rewinds the fill position
  p_ptr_rewind_r10: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (ptr == '0));
  // R2: the mode in force does not change while a burst is pending or running
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    busy_all |=> $stable(cfg_eff));
  // R3: in read-prefetch mode the buffer is never written
  p_no_store_read_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_eff |-> !ram_we);
endmodule

// File: rtl/fpb_engine.sv
module fpb_engine
  import fpb_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  localparam int DEPTH    = BUF_BYTES / 4,
  localparam int IW       = $clog2(DEPTH),
  localparam int CW       = $clog2(BUF_BYTES + 8) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   addr,
  input  logic          four_b,
  output logic          rd_en,
  output logic [IW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi
);
  eng_state_t    state;
  logic [CW-1:0] byte_idx;
  logic [2:0]    bit_cnt;
  logic          phase;
  logic [7:0]    sh;
  logic [31:0]   addr_q;
  logic          four_q;
  logic          sclk_q, cs_q, mosi_q, done_q;

  logic [CW-1:0] hdr_len, total, data_idx;
  logic [1:0]    sel;
  logic [7:0]    hdr_byte;
  logic [1:0]    lane;

  assign hdr_len  = four_q ? CW'(5) : CW'(4);
  assign total    = hdr_len + CW'(BUF_BYTES);
  assign data_idx = byte_idx - hdr_len;
  assign lane     = data_idx[1:0];
  assign sel      = 2'(hdr_len - CW'(1) - byte_idx);
  assign hdr_byte = (byte_idx == '0) ? PP_OPCODE : addr_q[{sel, 3'b000} +: 8];
  assign rd_en    = (state == ST_PREP) && (byte_idx >= hdr_len);
  assign rd_addr  = data_idx[IW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      bit_cnt  <= '0;
      phase    <= 1'b0;
      sh       <= '0;
      addr_q   <= '0;
      four_q   <= 1'b0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (start) begin
            addr_q   <= addr;
            four_q   <= four_b;
            byte_idx <= '0;
            cs_q     <= 1'b0;
            state    <= ST_PREP;
          end
        end
        ST_PREP: begin
          sclk_q  <= 1'b0;
          phase   <= 1'b0;
          bit_cnt <= '0;
          if (byte_idx < hdr_len) begin
            sh    <= hdr_byte;
            state <= ST_SHIFT;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          sh    <= rd_data[{lane, 3'b000} +: 8];
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!phase) begin
            mosi_q <= sh[7];
            sclk_q <= 1'b0;
            phase  <= 1'b1;
          end else begin
            sclk_q  <= 1'b1;
            sh      <= {sh[6:0], 1'b0};
            phase   <= 1'b0;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              byte_idx <= byte_idx + CW'(1);
              state    <= (byte_idx == total - CW'(1)) ? ST_TAIL : ST_PREP;
            end
          end
        end
        ST_TAIL: begin
          sclk_q <= 1'b0;
          state  <= ST_END;
        end
        ST_END: begin
          cs_q   <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE) || done_q;
  assign done = done_q;
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = mosi_q;

  // R11: no clock edges with the flash deselected
  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> !sclk_q);
  // R7: chip select stays low for every shifted bit
  p_cs_low_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> !cs_q);
  // R7: the data line only changes while the clock is low
  p_mosi_stable_r7: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> $stable(mosi_q));
  // R8: the completion pulse coincides with release of chip select
  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $rose(cs_q));
endmodule

// File: rtl/flash_page_buffer.sv
module flash_page_buffer
  import fpb_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  localparam int DEPTH    = BUF_BYTES / 4,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  logic          eng_busy, eng_done, start;
  logic [31:0]   addr;
  logic          four_b;
  logic          ram_we, ram_re;
  logic [IW-1:0] ram_waddr, ram_raddr;
  logic [31:0]   ram_wdata, ram_rdata;

  fpb_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .start_o(start), .addr_o(addr), .four_b_o(four_b),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  fpb_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk(clk),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  fpb_engine #(.BUF_BYTES(BUF_BYTES)) u_engine (
    .clk(clk), .rst(rst),
    .start(start), .addr(addr), .four_b(four_b),
    .rd_en(ram_re), .rd_addr(ram_raddr), .rd_data(ram_rdata),
    .busy(eng_busy), .done(eng_done),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );
endmodule

// File: tb/flash_page_buffer_test.sv
module flash_page_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 128;
  localparam logic [7:0] A_CMD = 8'h00, A_AD0 = 8'h10, A_AD1 = 8'h14, A_AD2 = 8'h18,
                         A_MODE = 8'h20, A_CFG = 8'h24, A_DATA = 8'h28, A_AD3 = 8'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;

  int checks = 0, failures = 0;
  int frames = 0, nbytes = 0, bitc = 0, sclk_err = 0;
  logic [7:0] cur = '0;
  logic [7:0] cap [0:199];

  flash_page_buffer uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge spi_cs_n) begin
    frames = frames + 1; nbytes = 0; bitc = 0;
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      cur = {cur[6:0], spi_mosi};
      bitc = bitc + 1;
      if (bitc == 8) begin
        if (nbytes < 200) cap[nbytes] = cur;
        nbytes = nbytes + 1; bitc = 0;
      end
    end
  end
  always @(negedge clk) if (!rst && spi_cs_n && spi_sclk) sclk_err = sclk_err + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wen = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic fill(input logic [7:0] seed, input int nwords);
    for (int i = 0; i < nwords; i++) begin
      logic [7:0] b0;
      b0 = seed + 8'(4*i);
      wr(A_DATA, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
    end
  endtask

  task automatic wait_idle(output int polls);
    logic [31:0] d;
    polls = 0;
    do begin rd(A_CMD, d); polls++; end while (d[4] && polls < 5000);
  endtask

  task automatic set_page_mode(input bit m);
    logic [31:0] d;
    int n = 0;
    wr(A_CFG, {31'h0, m});
    do begin rd(A_CFG, d); n++; end while (d[0] != m && n < 50);
    check(d[0] == m, "R2 mode readback", d, {31'h0, m});
  endtask

  task automatic set_addr(input logic [31:0] a, input bit four);
    wr(A_AD0, {24'h0, a[7:0]});   wr(A_AD1, {24'h0, a[15:8]});
    wr(A_AD2, {24'h0, a[23:16]}); wr(A_AD3, {24'h0, a[31:24]});
    wr(A_MODE, four ? 32'h10 : 32'h0);
  endtask

  task automatic run_burst(input string req);
    logic [31:0] d;
    int polls;
    wr(A_CMD, 32'h10);
    rd(A_CMD, d);
    check(d[4] == 1'b1, "R8 busy during burst", d, 32'h10);
    wait_idle(polls);
    check(polls < 5000, req, polls, 0);
  endtask

  task automatic check_stream(input logic [31:0] a, input bit four,
                              input logic [7:0] seed, input string req);
    int hdr = four ? 5 : 4;
    int bad = 0;
    logic [7:0] e;
    check(nbytes == hdr + PAGE, {req, " byte count"}, nbytes, hdr + PAGE);
    check(cap[0] == 8'h02, {req, " opcode"}, cap[0], 8'h02);
    for (int i = 1; i < hdr; i++) begin
      e = a[8*(hdr-1-i) +: 8];
      if (cap[i] !== e) bad++;
    end
    check(bad == 0, {req, " address bytes"}, bad, 0);
    bad = 0;
    for (int j = 0; j < PAGE; j++) begin
      e = seed + 8'(j);
      if (cap[hdr+j] !== e) begin
        if (bad == 0) $display("  first data mismatch at %0d: %h vs %h", j, cap[hdr+j], e);
        bad++;
      end
    end
    check(bad == 0, {req, " data bytes"}, bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [7:0] regs [8] = '{A_CMD, A_AD0, A_AD1, A_AD2, A_AD3, A_MODE, A_CFG, A_DATA};
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 idle pins",
          {30'h0, spi_cs_n, spi_sclk}, 32'h2);
    for (int i = 0; i < 8; i++) begin
      rd(regs[i], d);
      check(d == 32'h0, "R1 reset readback", d, 32'h0);
    end
  endtask

  task automatic t_addr_regs;
    logic [31:0] d;
    set_addr(32'hA1B2C3D4, 1'b1);
    rd(A_AD0, d); check(d == 32'hD4, "R5 addr byte0", d, 32'hD4);
    rd(A_AD1, d); check(d == 32'hC3, "R5 addr byte1", d, 32'hC3);
    rd(A_AD2, d); check(d == 32'hB2, "R5 addr byte2", d, 32'hB2);
    rd(A_AD3, d); check(d == 32'hA1, "R5 addr byte3", d, 32'hA1);
    rd(A_MODE, d); check(d == 32'h10, "R6 mode readback", d, 32'h10);
  endtask

  task automatic t_read_mode_ignored;
    logic [31:0] d;
    int f0 = frames;
    fill(8'hF0, 5);
    wr(A_CMD, 32'h10);
    rd(A_CMD, d); check(d[4] == 1'b0, "R9 no busy in read mode", d, 32'h0);
    repeat (40) @(negedge clk);
    check(frames == f0, "R9 no chip select in read mode", frames, f0);
    set_page_mode(1'b1);
    set_addr(32'h00123456, 1'b0);
    fill(8'h40, 32);
    run_burst("R7 burst completes");
    check(frames == f0 + 1, "R7 one frame", frames, f0 + 1);
    check_stream(32'h00123456, 1'b0, 8'h40, "R3 R6 3-byte page");
  endtask

  task automatic t_four_byte_and_rewind;
    set_addr(32'hA1B2C3D4, 1'b1);
    fill(8'h80, 32);
    run_burst("R7 4-byte burst completes");
    check_stream(32'hA1B2C3D4, 1'b1, 8'h80, "R6 R10 4-byte page");
  endtask

  task automatic t_overflow;
    set_addr(32'h00000100, 1'b0);
    fill(8'h10, 32);
    wr(A_DATA, 32'hDEADBEEF);
    run_burst("R4 burst completes");
    check_stream(32'h00000100, 1'b0, 8'h10, "R4 extra word dropped");
  endtask

  task automatic t_mode_change_in_burst;
    logic [31:0] d;
    int polls, f0;
    fill(8'h33, 32);
    wr(A_CMD, 32'h10);
    wr(A_CFG, 32'h0);
    rd(A_CFG, d); check(d[0] == 1'b1, "R2 mode held during burst", d, 32'h1);
    wait_idle(polls);
    repeat (3) @(negedge clk);
    rd(A_CFG, d); check(d[0] == 1'b0, "R2 mode applied after burst", d, 32'h0);
    check_stream(32'h00000100, 1'b0, 8'h33, "R7 page under mode change");
    f0 = frames;
    wr(A_CMD, 32'h10);
    repeat (40) @(negedge clk);
    check(frames == f0, "R9 start ignored after switch back", frames, f0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr_regs();
    t_read_mode_ignored();
    t_four_byte_and_rewind();
    t_overflow();
    t_mode_change_in_burst();
    check(sclk_err == 0, "R11 clock low while deselected", sclk_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule